// File: doc/BRIEF.md
# Two-Thread Rename Register File

This block is the integer register storage and rename-allocation core for a core running two hardware threads. Each thread has a 64-bit architecture with eight registers. A 64-bit value is kept as two 32-bit physical words, a low word and a high word. The 256-word physical array is split into three regions:

- words 0 to 31 are the home locations of both threads' architectural state;
- words 32 to 143 are the private rename pool of thread 0;
- words 144 to 255 are the private rename pool of thread 1.

Because the pools are private, one thread can hold almost all of its own pool while the other thread stalls or recovers.

Each thread has its own allocation and release ports. An allocation grants the two lowest free words of that thread's pool and binds them to a chosen architectural register in the speculative rename map. Software-invisible commit updates a committed copy of the map. A flush restores the speculative map from the committed copy and reclaims every pool word the committed copy does not hold, all in one cycle. The storage array has two registered read ports and one write port, with write-through forwarding.

Top module: `dual_thread_regfile`

## Requirements
- R1: After reset, the map of thread t gives architectural register a the low word 16*t+2*a and the high word 16*t+2*a+1, and every pool word is free.
- R2: When alloc_req is high and alloc_stall is low, alloc_lo and alloc_hi show, in the same cycle, the lowest and second-lowest free words of that thread's pool. Thread 0's pool is 32..143 and thread 1's pool is 144..255. From the next cycle, the lookup of the chosen architectural register returns that pair.
- R3: alloc_stall is high, and no word is taken, while the thread has fewer than two free pool words.
- R4: A release and an allocation on the same thread in the same cycle both take effect. A released word cannot be granted in the cycle of its release, and can be granted from the next cycle.
- R5: In a flush cycle the thread's alloc_stall is high. On the next cycle its map equals the committed copy, including a commit made in the flush cycle, and every pool word not named by the committed copy is free.
- R6: Allocation, release, commit and flush on one thread leave the other thread's map and pool unchanged.
- R7: Each read port returns, one cycle after the address is presented, the word last written to that address.
- R8: A read presented in the same cycle as a write to the same address returns the newly written data.
- R9: With wr_en low, the write port does not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 2 | Per-thread allocation request |
| alloc_arch | input | 2x3 | Per-thread architectural destination register |
| alloc_stall | output | 2 | Per-thread: fewer than two free words, or flush in progress |
| alloc_lo | output | 2x8 | Per-thread granted low-word index |
| alloc_hi | output | 2x8 | Per-thread granted high-word index |
| free_req | input | 2 | Per-thread release request |
| free_lo | input | 2x8 | First word released |
| free_hi | input | 2x8 | Second word released (may equal free_lo) |
| commit_req | input | 2 | Per-thread commit of one mapping |
| commit_arch | input | 2x3 | Architectural register being committed |
| commit_lo | input | 2x8 | Committed low-word index |
| commit_hi | input | 2x8 | Committed high-word index |
| flush | input | 2 | Per-thread speculative-state flush |
| look_arch | input | 2x3 | Per-thread map lookup register |
| look_lo | output | 2x8 | Speculative low-word index of look_arch |
| look_hi | output | 2x8 | Speculative high-word index of look_arch |
| wr_en | input | 1 | Array write enable |
| wr_addr | input | 8 | Array write address |
| wr_data | input | 32 | Array write data |
| rd_addr_a | input | 8 | Read port A address |
| rd_data_a | output | 32 | Read port A data, one cycle later |
| rd_addr_b | input | 8 | Read port B address |
| rd_data_b | output | 32 | Read port B data, one cycle later |

## Verification
A corrupted free mask appears at once on the allocation outputs. The next grant is then either a word already handed out, a word outside the thread's pool, or a stall raised while many words remain. A bad map shows on the lookup port in the cycle after the allocation, commit or flush that wrote it. A state leak between threads shows as a changed lookup or grant on the untouched thread right after the other thread acts. An array or forwarding fault appears on the read data one cycle after the read address is presented.

// File: rtl/rfp_pkg.sv
// Shared sizes and types of the two-thread rename register file.
// Assumes exactly two threads with equal private pools.
package rfp_pkg;
    localparam int XLEN       = 32;                        // physical word width
    localparam int NTHR       = 2;                         // hardware threads
    localparam int NARCH      = 8;                         // 64-bit registers per thread
    localparam int WPR        = 2;                         // words per architectural register
    localparam int POOL       = 112;                       // rename words per thread
    localparam int ARCH_WORDS = NTHR * NARCH * WPR;        // home region size
    localparam int DEPTH      = ARCH_WORDS + NTHR * POOL;  // whole array
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int AR_W       = $clog2(NARCH);
    localparam int NRD        = 2;                         // read ports

    typedef logic [IDX_W-1:0] pidx_t;
    typedef struct packed {
        pidx_t hi;
        pidx_t lo;
    } pair_t;
endpackage

// File: rtl/rf_pool_alloc.sv
// Free-word tracker for one thread's private pool.
// Grants the two lowest free words, honours a same-cycle release,
// and reloads the mask from the committed-map keep set on flush.
// Assumes release indices belong to this pool; others are ignored.
module rf_pool_alloc
    import rfp_pkg::*;
#(
    parameter int BASE = ARCH_WORDS,
    parameter int PSZ  = POOL
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_req,
    input  logic           flush,
    input  logic           free_req,
    input  pidx_t          free_lo,
    input  pidx_t          free_hi,
    input  logic [PSZ-1:0] keep_mask,
    output logic           stall,
    output logic           fire,
    output pidx_t          gnt_lo,
    output pidx_t          gnt_hi
);
    localparam int LOC_W = $clog2(PSZ);

    logic [PSZ-1:0]   free_q, take, rel;
    logic [LOC_W-1:0] loc1, loc2;
    logic             have1, have2;

    // Find the lowest and second-lowest free words.
    always_comb begin
        have1 = 1'b0;
        have2 = 1'b0;
        loc1  = '0;
        loc2  = '0;
        for (int j = 0; j < PSZ; j++) begin
            if (free_q[j]) begin
                if (!have1) begin
                    have1 = 1'b1;
                    loc1  = LOC_W'(j);
                end else if (!have2) begin
                    have2 = 1'b1;
                    loc2  = LOC_W'(j);
                end
            end
        end
    end

    assign stall  = flush || !have2;
    assign fire   = alloc_req && !stall;
    assign gnt_lo = IDX_W'(BASE) + IDX_W'(loc1);
    assign gnt_hi = IDX_W'(BASE) + IDX_W'(loc2);

    // One-hot masks of words taken and released this cycle.
    always_comb begin
        take = '0;
        rel  = '0;
        if (fire) begin
            take[loc1] = 1'b1;
            take[loc2] = 1'b1;
        end
        for (int j = 0; j < PSZ; j++) begin
            if (free_req && (free_lo == IDX_W'(BASE + j) || free_hi == IDX_W'(BASE + j)))
                rel[j] = 1'b1;
        end
    end

    // Free-mask register: reset all free, flush to keep set, else take/release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            free_q <= '1;
        else if (flush)
            free_q <= ~keep_mask;
        else
            free_q <= (free_q & ~take) | rel;
    end
endmodule

// File: rtl/rf_rename_map.sv
// Speculative and committed rename maps for one thread.
// Both reset to the thread's home words; flush copies committed to
// speculative and reports which pool words the committed map holds.
module rf_rename_map
    import rfp_pkg::*;
#(
    parameter int TID       = 0,
    parameter int POOL_BASE = ARCH_WORDS,
    parameter int PSZ       = POOL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [AR_W-1:0]  alloc_arch,
    input  pidx_t            gnt_lo,
    input  pidx_t            gnt_hi,
    input  logic             commit_req,
    input  logic [AR_W-1:0]  commit_arch,
    input  pidx_t            commit_lo,
    input  pidx_t            commit_hi,
    input  logic             flush,
    input  logic [AR_W-1:0]  look_arch,
    output pidx_t            look_lo,
    output pidx_t            look_hi,
    output logic [PSZ-1:0]   keep_mask
);
    pair_t spec_q [NARCH];
    pair_t com_q  [NARCH];
    pair_t com_nx [NARCH];

    // Committed map including this cycle's commit.
    always_comb begin
        com_nx = com_q;
        if (commit_req)
            com_nx[commit_arch] = '{hi: commit_hi, lo: commit_lo};
    end

    // Pool words named by the committed map survive a flush.
    always_comb begin
        keep_mask = '0;
        for (int j = 0; j < PSZ; j++)
            for (int a = 0; a < NARCH; a++)
                if (com_nx[a].lo == IDX_W'(POOL_BASE + j) || com_nx[a].hi == IDX_W'(POOL_BASE + j))
                    keep_mask[j] = 1'b1;
    end

    // Committed map register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NARCH; a++)
                com_q[a] <= '{hi: IDX_W'(TID*NARCH*WPR + WPR*a + 1), lo: IDX_W'(TID*NARCH*WPR + WPR*a)};
        end else begin
            com_q <= com_nx;
        end
    end

    // Speculative map register: flush restores, grant rebinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NARCH; a++)
                spec_q[a] <= '{hi: IDX_W'(TID*NARCH*WPR + WPR*a + 1), lo: IDX_W'(TID*NARCH*WPR + WPR*a)};
        end else if (flush) begin
            spec_q <= com_nx;
        end else if (alloc_fire) begin
            spec_q[alloc_arch] <= '{hi: gnt_hi, lo: gnt_lo};
        end
    end

    assign look_lo = spec_q[look_arch].lo;
    assign look_hi = spec_q[look_arch].hi;
endmodule

// File: rtl/rf_array.sv
// Physical word storage with NRD registered read ports and one
// write port; a read of the address being written returns new data.
module rf_array
    import rfp_pkg::*;
#(
    parameter int D  = DEPTH,
    parameter int W  = XLEN,
    parameter int NR = NRD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  pidx_t                wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic [NR-1:0][IDX_W-1:0] rd_addr,
    output logic [NR-1:0][W-1:0] rd_data
);
    logic [W-1:0] mem [D];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    for (genvar p = 0; p < NR; p++) begin : g_rd
        // Registered read with write-through forwarding.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[p] <= '0;
            else if (wr_en && wr_addr == rd_addr[p])
                rd_data[p] <= wr_data;
            else
                rd_data[p] <= mem[rd_addr[p]];
        end
    end
endmodule

// File: rtl/dual_thread_regfile.sv
// Two-thread rename register file: home region for both threads'
// architectural state, one private rename pool per thread, and a
// 2-read 1-write word array. Assumes callers release whole pairs.
module dual_thread_regfile
    import rfp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NTHR-1:0]            alloc_req,
    input  logic [NTHR-1:0][AR_W-1:0]  alloc_arch,
    output logic [NTHR-1:0]            alloc_stall,
    output logic [NTHR-1:0][IDX_W-1:0] alloc_lo,
    output logic [NTHR-1:0][IDX_W-1:0] alloc_hi,
    input  logic [NTHR-1:0]            free_req,
    input  logic [NTHR-1:0][IDX_W-1:0] free_lo,
    input  logic [NTHR-1:0][IDX_W-1:0] free_hi,
    input  logic [NTHR-1:0]            commit_req,
    input  logic [NTHR-1:0][AR_W-1:0]  commit_arch,
    input  logic [NTHR-1:0][IDX_W-1:0] commit_lo,
    input  logic [NTHR-1:0][IDX_W-1:0] commit_hi,
    input  logic [NTHR-1:0]            flush,
    input  logic [NTHR-1:0][AR_W-1:0]  look_arch,
    output logic [NTHR-1:0][IDX_W-1:0] look_lo,
    output logic [NTHR-1:0][IDX_W-1:0] look_hi,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_addr,
    input  logic [XLEN-1:0]            wr_data,
    input  logic [IDX_W-1:0]           rd_addr_a,
    output logic [XLEN-1:0]            rd_data_a,
    input  logic [IDX_W-1:0]           rd_addr_b,
    output logic [XLEN-1:0]            rd_data_b
);
    logic [NTHR-1:0]            fire;
    logic [NTHR-1:0][POOL-1:0]  keep;
    logic [NRD-1:0][IDX_W-1:0]  rd_addr;
    logic [NRD-1:0][XLEN-1:0]   rd_data;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        localparam int PBASE = ARCH_WORDS + t * POOL;

        rf_pool_alloc #(.BASE(PBASE), .PSZ(POOL)) u_pool (
            .clk(clk), .rst_n(rst_n),
            .alloc_req(alloc_req[t]), .flush(flush[t]),
            .free_req(free_req[t]), .free_lo(free_lo[t]), .free_hi(free_hi[t]),
            .keep_mask(keep[t]),
            .stall(alloc_stall[t]), .fire(fire[t]),
            .gnt_lo(alloc_lo[t]), .gnt_hi(alloc_hi[t])
        );

        rf_rename_map #(.TID(t), .POOL_BASE(PBASE), .PSZ(POOL)) u_map (
            .clk(clk), .rst_n(rst_n),
            .alloc_fire(fire[t]), .alloc_arch(alloc_arch[t]),
            .gnt_lo(alloc_lo[t]), .gnt_hi(alloc_hi[t]),
            .commit_req(commit_req[t]), .commit_arch(commit_arch[t]),
            .commit_lo(commit_lo[t]), .commit_hi(commit_hi[t]),
            .flush(flush[t]), .look_arch(look_arch[t]),
            .look_lo(look_lo[t]), .look_hi(look_hi[t]),
            .keep_mask(keep[t])
        );
    end

    assign rd_addr   = {rd_addr_b, rd_addr_a};
    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    rf_array #(.D(DEPTH), .W(XLEN), .NR(NRD)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/rf_checker.sv
// Port-level properties of the rename register file, bound to the top.
module rf_checker
    import rfp_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [NTHR-1:0]            alloc_req,
    input logic [NTHR-1:0]            alloc_stall,
    input logic [NTHR-1:0][IDX_W-1:0] alloc_lo,
    input logic [NTHR-1:0][IDX_W-1:0] alloc_hi,
    input logic [NTHR-1:0]            free_req,
    input logic [NTHR-1:0]            flush,
    input logic                       wr_en,
    input logic [IDX_W-1:0]           wr_addr,
    input logic [XLEN-1:0]            wr_data,
    input logic [IDX_W-1:0]           rd_addr_a,
    input logic [IDX_W-1:0]           rd_addr_b,
    input logic [XLEN-1:0]            rd_data_a,
    input logic [XLEN-1:0]            rd_data_b
);
    localparam int P0 = ARCH_WORDS;
    localparam int P1 = ARCH_WORDS + POOL;

    assert_pool0_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req[0] && !alloc_stall[0]) |->
        (32'(alloc_lo[0]) >= P0 && 32'(alloc_lo[0]) < P1 &&
         32'(alloc_hi[0]) >= P0 && 32'(alloc_hi[0]) < P1 && alloc_lo[0] < alloc_hi[0]));

    assert_pool1_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req[1] && !alloc_stall[1]) |->
        (32'(alloc_lo[1]) >= P1 && 32'(alloc_hi[1]) >= P1 && alloc_lo[1] < alloc_hi[1]));

    assert_no_regrant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req[0] && !alloc_stall[0] && !flush[0] && !free_req[0]) |=>
        !(alloc_req[0] && !alloc_stall[0] &&
          (alloc_lo[0] == $past(alloc_lo[0]) || alloc_hi[0] == $past(alloc_lo[0]))));

    assert_flush_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush[1] |-> alloc_stall[1]);

    assert_flush_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush[0] |=> (!alloc_stall[0] || flush[0]));

    assert_fwd_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr_a == wr_addr) |=> rd_data_a == $past(wr_data));

    assert_fwd_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr_b == wr_addr) |=> rd_data_b == $past(wr_data));
endmodule

bind dual_thread_regfile rf_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_stall(alloc_stall),
    .alloc_lo(alloc_lo), .alloc_hi(alloc_hi),
    .free_req(free_req), .flush(flush),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
);

// File: tb/sim_dual_thread_regfile.sv
module sim_dual_thread_regfile;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]      alloc_req, alloc_stall, free_req, commit_req, flush;
    logic [1:0][2:0] alloc_arch, commit_arch, look_arch;
    logic [1:0][7:0] alloc_lo, alloc_hi, free_lo, free_hi, commit_lo, commit_hi, look_lo, look_hi;
    logic            wr_en;
    logic [7:0]      wr_addr, rd_addr_a, rd_addr_b;
    logic [31:0]     wr_data, rd_data_a, rd_data_b;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_thread_regfile u0 (.*);

    // {address, data} pairs for the array walk
    localparam logic [39:0] VEC [6] = '{
        {8'd0,   32'h1234_5678}, {8'd255, 32'hDEAD_BEEF}, {8'd31,  32'h0000_0001},
        {8'd32,  32'hFFFF_FFFF}, {8'd144, 32'hA5A5_5A5A}, {8'd100, 32'h0F0F_00F0}};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        alloc_req = '0; alloc_arch = '0; free_req = '0; free_lo = '0; free_hi = '0;
        commit_req = '0; commit_arch = '0; commit_lo = '0; commit_hi = '0;
        flush = '0; look_arch = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset map and state
        look_arch[0] = 3'd3; look_arch[1] = 3'd2; #1;
        chk("R1 t0 a3 lo", 32'(look_lo[0]), 32'd6);
        chk("R1 t0 a3 hi", 32'(look_hi[0]), 32'd7);
        chk("R1 t1 a2 lo", 32'(look_lo[1]), 32'd20);
        chk("R1 t1 a2 hi", 32'(look_hi[1]), 32'd21);
        chk("R1 stall", 32'(alloc_stall), 32'd0);
        chk("R7 reset read", rd_data_a, 32'd0);

        // array walk from the vector table (R7 via both ports)
        for (int i = 0; i < 6; i++) begin
            wr_en = 1; wr_addr = VEC[i][39:32]; wr_data = VEC[i][31:0];
            tick();
            wr_en = 0; rd_addr_a = VEC[i][39:32]; rd_addr_b = VEC[0][39:32];
            tick();
            chk("R7 port a", rd_data_a, VEC[i][31:0]);
            chk("R7 port b", rd_data_b, VEC[0][31:0]);
        end
        // R8: same-cycle forwarding
        wr_en = 1; wr_addr = 8'd50; wr_data = 32'hCAFE_0001; rd_addr_a = 8'd50; rd_addr_b = 8'd50;
        tick();
        chk("R8 fwd a", rd_data_a, 32'hCAFE_0001);
        chk("R8 fwd b", rd_data_b, 32'hCAFE_0001);
        // R9: disabled write has no effect
        wr_en = 0; wr_data = 32'h0BAD_0BAD;
        tick();
        tick();
        chk("R9 no write", rd_data_a, 32'hCAFE_0001);

        // R2: lowest-pair grants
        alloc_req[0] = 1; alloc_arch[0] = 3'd5; #1;
        chk("R2 t0 lo", 32'(alloc_lo[0]), 32'd32);
        chk("R2 t0 hi", 32'(alloc_hi[0]), 32'd33);
        tick();
        alloc_arch[0] = 3'd6; alloc_req[1] = 1; alloc_arch[1] = 3'd0;
        look_arch[0] = 3'd5; #1;
        chk("R2 map update", 32'(look_lo[0]), 32'd32);
        chk("R2 t0 second", 32'(alloc_lo[0]), 32'd34);
        chk("R2 t1 first", 32'(alloc_lo[1]), 32'd144);
        chk("R2 t1 first hi", 32'(alloc_hi[1]), 32'd145);
        tick();
        // R4: allocate and release together
        alloc_req[1] = 0; alloc_arch[0] = 3'd7; free_req[0] = 1; free_lo[0] = 8'd32; free_hi[0] = 8'd33; #1;
        chk("R4 freed not reused", 32'(alloc_lo[0]), 32'd36);
        tick();
        free_req[0] = 0; alloc_arch[0] = 3'd5; #1;
        chk("R4 freed reused next", 32'(alloc_lo[0]), 32'd32);
        tick();
        alloc_req[0] = 0;
        commit_req[0] = 1; commit_arch[0] = 3'd6; commit_lo[0] = 8'd34; commit_hi[0] = 8'd35;
        tick();
        commit_req[0] = 0; flush[0] = 1; #1;
        chk("R5 stall in flush", 32'(alloc_stall[0]), 32'd1);
        tick();
        flush[0] = 0; look_arch[0] = 3'd5; look_arch[1] = 3'd0; #1;
        chk("R5 restore a5", 32'(look_lo[0]), 32'd10);
        chk("R6 t1 map kept", 32'(look_lo[1]), 32'd144);
        look_arch[0] = 3'd6; #1;
        chk("R5 committed a6", 32'(look_hi[0]), 32'd35);
        look_arch[0] = 3'd7; #1;
        chk("R5 restore a7", 32'(look_lo[0]), 32'd14);
        alloc_req = 2'b11; #1;
        chk("R5 reclaimed", 32'(alloc_lo[0]), 32'd32);
        chk("R5 kept held", 32'(alloc_hi[0]), 32'd33);
        chk("R6 t1 pool kept", 32'(alloc_lo[1]), 32'd146);

        // R3: exhaust thread 1
        do_reset();
        for (int i = 0; i < 56; i++) begin
            alloc_req[1] = 1; alloc_arch[1] = 3'(i % 8); #1;
            if (i == 55) begin
                chk("R3 last lo", 32'(alloc_lo[1]), 32'd254);
                chk("R3 last hi", 32'(alloc_hi[1]), 32'd255);
            end
            tick();
        end
        chk("R3 empty stall", 32'(alloc_stall[1]), 32'd1);
        alloc_req[1] = 0; free_req[1] = 1; free_lo[1] = 8'd200; free_hi[1] = 8'd200;
        tick();
        free_req[1] = 0; alloc_req[1] = 1; #1;
        chk("R3 one free stall", 32'(alloc_stall[1]), 32'd1);
        alloc_req[1] = 0; free_req[1] = 1; free_lo[1] = 8'd201; free_hi[1] = 8'd201;
        tick();
        free_req[1] = 0; alloc_req = 2'b11; alloc_arch[0] = 3'd0; #1;
        chk("R3 two free", 32'(alloc_stall[1]), 32'd0);
        chk("R3 regrant", 32'(alloc_lo[1]), 32'd200);
        chk("R6 t0 unaffected", 32'(alloc_lo[0]), 32'd32);
        tick();
        alloc_req = '0; flush[1] = 1;
        tick();
        flush[1] = 0; look_arch[1] = 3'd3; look_arch[0] = 3'd0; alloc_req[1] = 1; #1;
        chk("R5 t1 refill", 32'(alloc_lo[1]), 32'd144);
        chk("R5 t1 map", 32'(look_lo[1]), 32'd22);
        chk("R6 t0 map kept", 32'(look_lo[0]), 32'd32);
        tick();
        idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule